// File: doc/BRIEF.md
# Error-Feedback Noise-Shaping Modulator

This block turns a fine-resolution fixed-point sample stream into a coarse multi-level integer stream that a small DAC can drive. On each accepted sample it adds a filtered copy of past quantization errors to the new input. It then takes the integer part of that sum as the output level and keeps the fractional remainder as the new error. The error path is delayed by at least one register, so the loop contains no combinational cycle.

The feedback filter is the non-zero-delay part of H(z) = (1 − z⁻¹)^m. The order m is a parameter from 1 to 3. The input reaches the output with unit gain, and the quantization error is shaped by H(z), which pushes its power towards half the sample rate. A higher order shapes the noise harder but widens the range of output levels. The output port therefore grows by one bit for each order. Dither, the analog converter and reconstruction filtering are outside this block.

Top module: `sdm_errfb_mod`

## Requirements
- R1: A synchronous active-high reset clears every stored error and drives `out_level` to 0 on the next clock edge.
- R2: On a cycle where `in_valid` is low, `out_level` and the error history keep their values.
- R3: On each valid sample, the sum is `in_sample + fb`. For order 1, fb = e1. For order 2, fb = 2·e1 − e2. For order 3, fb = 3·e1 − 3·e2 + e3. Here ek is the stored error from k valid samples earlier, as an unsigned number with FRAC_W fractional bits.
- R4: The quantizer rounds the sum towards minus infinity (floor) to give the integer level. The stored error is the sum minus level·2^FRAC_W, which always lies in [0, 2^FRAC_W). A sample of −0.5 taken just after reset gives level −1.
- R5: While every valid input since reset lies in [0, 1), `out_level` stays between −(2^(ORDER−1) − 1) and 2^(ORDER−1).
- R6: Unit signal gain. Counted from reset over any run, |Σ out_level·2^FRAC_W − Σ in_sample| < 2^(ORDER−1)·2^FRAC_W.
- R7: While every valid input since reset is zero, `out_level` stays at 0.
- R8: The input is signed two's complement with INT_W integer bits (sign included) and FRAC_W fractional bits. The output is signed with INT_W+ORDER bits. A valid sample on one clock edge sets `out_level` at that edge, so an integer input k taken just after reset appears as k one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a sample to accept on this edge |
| in_sample | input | INT_W+FRAC_W | Signed fixed-point input sample |
| out_level | output | INT_W+ORDER | Signed coarse output level, registered |

## Verification
The assertions check on every cycle that reset clears the output, that idle cycles leave the output unchanged, that the level stays inside its order-dependent range while inputs stay in [0, 1), and that an all-zero input gives a zero output. The exact level sequence depends on the weighted error history, on floor rounding and on the unit signal gain. Only the bench's scenarios can show these, using a reference model for orders 1, 2 and 3. The scenarios are rational DC inputs (0.1 and 0.1 + 1/1024), pseudo-random fractions, negative and integer samples, and idle gaps.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    localparam int SDM_ORDER_MAX = 3;

    // Shift-and-add form used to build one feedback term
    typedef enum logic [1:0] {
        SA_PASS   = 2'd1,
        SA_DOUBLE = 2'd2,
        SA_TRIPLE = 2'd3
    } shift_add_e;

    function automatic int binom(input int n, input int k);
        int r;
        r = 1;
        for (int i = 0; i < k; i++) begin
            r = r * (n - i) / (i + 1);
        end
        return r;
    endfunction

    // Weight applied to the error from 'tap' samples back: -(coef of z^-tap in (1-z^-1)^order)
    function automatic int fb_weight(input int order, input int tap);
        return ((tap % 2) == 1) ? binom(order, tap) : -binom(order, tap);
    endfunction

    function automatic shift_add_e shift_add_of(input int weight);
        int mag;
        mag = (weight < 0) ? -weight : weight;
        case (mag)
            3:       return SA_TRIPLE;
            2:       return SA_DOUBLE;
            default: return SA_PASS;
        endcase
    endfunction

endpackage

// File: rtl/sdm_err_hist.sv
module sdm_err_hist #(
    parameter int FRAC_W = 16,
    parameter int DEPTH  = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          shift_en,
    input  logic [FRAC_W-1:0]             new_err,
    output logic [DEPTH-1:0][FRAC_W-1:0]  taps
);

    always_ff @(posedge clk) begin
        if (rst) begin
            taps[0] <= '0;
        end else if (shift_en) begin
            taps[0] <= new_err;
        end
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                taps[i] <= '0;
            end else if (shift_en) begin
                taps[i] <= taps[i-1];
            end
        end
    end

endmodule

// File: rtl/sdm_fb_filter.sv
module sdm_fb_filter
    import sdm_pkg::*;
#(
    parameter int FRAC_W = 16,
    parameter int ORDER  = 3,
    parameter int FB_W   = FRAC_W + ORDER + 1
) (
    input  logic [ORDER-1:0][FRAC_W-1:0] taps,
    output logic signed [FB_W-1:0]       fb
);

    logic signed [FB_W-1:0] term [ORDER];

    for (genvar i = 0; i < ORDER; i++) begin : g_tap
        localparam int         WEIGHT = fb_weight(ORDER, i + 1);
        localparam shift_add_e FORM   = shift_add_of(WEIGHT);

        logic signed [FB_W-1:0] base;
        logic signed [FB_W-1:0] scaled;

        assign base = FB_W'({1'b0, taps[i]});

        if (FORM == SA_TRIPLE) begin : g_x3
            assign scaled = (base <<< 1) + base;
        end else if (FORM == SA_DOUBLE) begin : g_x2
            assign scaled = base <<< 1;
        end else begin : g_x1
            assign scaled = base;
        end

        if (WEIGHT < 0) begin : g_neg
            assign term[i] = -scaled;
        end else begin : g_pos
            assign term[i] = scaled;
        end
    end

    always_comb begin
        fb = '0;
        for (int i = 0; i < ORDER; i++) begin
            fb = fb + term[i];
        end
    end

endmodule

// File: rtl/sdm_quant.sv
module sdm_quant #(
    parameter int FRAC_W = 16,
    parameter int LVL_W  = 5
) (
    input  logic signed [FRAC_W+LVL_W-1:0] sum_in,
    output logic signed [LVL_W-1:0]        level,
    output logic        [FRAC_W-1:0]       residue
);

    // Floor of a two's complement value is the integer slice; the rest is the non-negative error
    assign level   = sum_in[FRAC_W+LVL_W-1:FRAC_W];
    assign residue = sum_in[FRAC_W-1:0];

endmodule

// File: rtl/sdm_errfb_mod.sv
module sdm_errfb_mod
    import sdm_pkg::*;
#(
    parameter int ORDER  = 3,
    parameter int INT_W  = 2,
    parameter int FRAC_W = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_valid,
    input  logic signed [INT_W+FRAC_W-1:0]   in_sample,
    output logic signed [INT_W+ORDER-1:0]    out_level
);

    localparam int LVL_W = INT_W + ORDER;
    localparam int SUM_W = FRAC_W + LVL_W;
    localparam int FB_W  = FRAC_W + ORDER + 1;

    logic [ORDER-1:0][FRAC_W-1:0] err_taps;
    logic signed [FB_W-1:0]       fb_val;
    logic signed [SUM_W-1:0]      loop_sum;
    logic signed [LVL_W-1:0]      level_next;
    logic        [FRAC_W-1:0]     err_next;

    sdm_err_hist #(
        .FRAC_W (FRAC_W),
        .DEPTH  (ORDER)
    ) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (in_valid),
        .new_err  (err_next),
        .taps     (err_taps)
    );

    sdm_fb_filter #(
        .FRAC_W (FRAC_W),
        .ORDER  (ORDER),
        .FB_W   (FB_W)
    ) u_filt (
        .taps (err_taps),
        .fb   (fb_val)
    );

    assign loop_sum = SUM_W'(in_sample) + SUM_W'(fb_val);

    sdm_quant #(
        .FRAC_W (FRAC_W),
        .LVL_W  (LVL_W)
    ) u_quant (
        .sum_in  (loop_sum),
        .level   (level_next),
        .residue (err_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_level <= '0;
        end else if (in_valid) begin
            out_level <= level_next;
        end
    end

endmodule

// File: rtl/sdm_errfb_chk.sv
module sdm_errfb_chk #(
    parameter int ORDER  = 3,
    parameter int INT_W  = 2,
    parameter int FRAC_W = 16
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           in_valid,
    input logic signed [INT_W+FRAC_W-1:0] in_sample,
    input logic signed [INT_W+ORDER-1:0]  out_level
);

    localparam int LVL_LO = -((2 ** (ORDER - 1)) - 1);
    localparam int LVL_HI = 2 ** (ORDER - 1);
    localparam int ONE    = 2 ** FRAC_W;

    logic in_unit;
    logic all_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_unit  <= 1'b1;
            all_zero <= 1'b1;
        end else if (in_valid) begin
            if (in_sample < 0 || in_sample >= ONE) in_unit <= 1'b0;
            if (in_sample != 0) all_zero <= 1'b0;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> out_level == '0);

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_level));

    assert_level_range_R5: assert property (@(posedge clk) disable iff (rst)
        in_unit |-> (out_level >= LVL_LO && out_level <= LVL_HI));

    assert_zero_in_zero_out_R7: assert property (@(posedge clk) disable iff (rst)
        all_zero |-> out_level == '0);

endmodule

bind sdm_errfb_mod sdm_errfb_chk #(
    .ORDER  (ORDER),
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .out_level (out_level)
);

// File: tb/sdm_errfb_mod_test.sv
module sdm_errfb_mod_test;

    localparam int  FRAC = 16;
    localparam longint ONE = 64'sd65536;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [17:0] in_sample = '0;
    logic signed [2:0] lvl1;
    logic signed [3:0] lvl2;
    logic signed [4:0] lvl3;

    always #2 clk = ~clk;

    sdm_errfb_mod #(.ORDER(1), .INT_W(2), .FRAC_W(FRAC)) u1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample), .out_level(lvl1));
    sdm_errfb_mod #(.ORDER(2), .INT_W(2), .FRAC_W(FRAC)) u2 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample), .out_level(lvl2));
    sdm_errfb_mod #(.ORDER(3), .INT_W(2), .FRAC_W(FRAC)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample), .out_level(lvl3));

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    longint hist [1:3][1:3];
    longint expv [1:3];
    longint sum_x [1:3];
    longint sum_y [1:3];
    longint poly [1:3][0:3];
    int unsigned lfsr = 32'h1234_5678;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expand (1 - z^-1)^m by repeated multiplication
    task automatic build_poly();
        for (int m = 1; m <= 3; m++) begin
            longint p [0:3];
            p = '{1, 0, 0, 0};
            for (int r = 0; r < m; r++) begin
                for (int k = 3; k >= 1; k--) p[k] = p[k] - p[k-1];
            end
            for (int k = 0; k <= 3; k++) poly[m][k] = p[k];
        end
    endtask

    task automatic model_reset();
        for (int m = 1; m <= 3; m++) begin
            for (int k = 1; k <= 3; k++) hist[m][k] = 0;
            expv[m] = 0; sum_x[m] = 0; sum_y[m] = 0;
        end
    endtask

    task automatic model_push(input longint x);
        for (int m = 1; m <= 3; m++) begin
            longint u, y, r;
            u = x;
            for (int k = 1; k <= m; k++) u = u - poly[m][k] * hist[m][k];
            y = u >>> FRAC;
            r = u - y * ONE;
            for (int k = 3; k >= 2; k--) hist[m][k] = hist[m][k-1];
            hist[m][1] = r;
            expv[m] = y;
            sum_x[m] += x;
            sum_y[m] += y;
        end
    endtask

    function automatic longint act_of(input int m);
        case (m)
            1: return longint'(lvl1);
            2: return longint'(lvl2);
            default: return longint'(lvl3);
        endcase
    endfunction

    task automatic compare_all(input string tag, input bit unit_phase);
        for (int m = 1; m <= 3; m++) begin
            longint a;
            a = act_of(m);
            check(a == expv[m], $sformatf("%s order%0d level", tag, m), a, expv[m]);
            if (unit_phase) begin
                longint lo, hi;
                lo = -((64'sd1 <<< (m - 1)) - 1);
                hi = 64'sd1 <<< (m - 1);
                check(a >= lo && a <= hi, $sformatf("R5 order%0d range", m), a, hi);
            end
        end
    endtask

    task automatic step(input bit v, input longint x, input bit unit_phase);
        in_valid  = v;
        in_sample = 18'(x);
        if (v) model_push(x);
        @(negedge clk);
        compare_all(v ? "R3" : "R2", unit_phase);
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0; in_sample = '0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        model_reset();
        for (int m = 1; m <= 3; m++) check(act_of(m) == 0, $sformatf("R1 order%0d reset", m), act_of(m), 0);
    endtask

    task automatic gain_check();
        for (int m = 1; m <= 3; m++) begin
            longint d, lim;
            d = sum_y[m] * ONE - sum_x[m];
            if (d < 0) d = -d;
            lim = (64'sd1 <<< (m - 1)) * ONE;
            check(d < lim, $sformatf("R6 order%0d gain", m), d, lim);
        end
    endtask

    function automatic longint next_frac();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return longint'(lfsr & 32'h0000_FFFF);
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        build_poly();
        model_reset();
        @(negedge clk);
        do_reset();

        // R7: zero input keeps every order at zero
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 0, 1'b1);
            for (int m = 1; m <= 3; m++) check(act_of(m) == 0, "R7 zero input", act_of(m), 0);
        end

        // R8: integer input passes through with one cycle of latency
        do_reset();
        step(1'b1, ONE, 1'b0);
        for (int m = 1; m <= 3; m++) check(act_of(m) == 1, $sformatf("R8 order%0d integer", m), act_of(m), 1);
        step(1'b1, -ONE, 1'b0);

        // R4: floor of -0.5 is -1
        do_reset();
        step(1'b1, -32768, 1'b0);
        for (int m = 1; m <= 3; m++) check(act_of(m) == -1, $sformatf("R4 order%0d floor", m), act_of(m), -1);
        step(1'b1, 65535, 1'b0);

        // DC 0.1 with idle gaps (R2, R3, R5, R6)
        do_reset();
        for (int i = 0; i < 300; i++) begin
            step((i % 7) != 3, 6554, 1'b1);
        end
        gain_check();

        // DC 0.1 + 1/1024
        do_reset();
        for (int i = 0; i < 300; i++) step(1'b1, 6554 + 64, 1'b1);
        gain_check();

        // Pseudo-random fractions in [0,1) with sparse valid
        do_reset();
        for (int i = 0; i < 400; i++) step((i % 5) != 0, next_frac(), 1'b1);
        gain_check();

        // Signed samples across [-2,2)
        do_reset();
        for (int i = 0; i < 200; i++) begin
            longint x;
            x = next_frac() + ((longint'(next_frac()) & 3) - 2) * ONE;
            step(1'b1, x, 1'b0);
        end
        gain_check();

        // Idle run holds the level (R2)
        for (int i = 0; i < 10; i++) step(1'b0, 12345, 1'b0);

        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

endmodule